// File: doc/BRIEF.md
# Raster Timing Generator for Parallel RGB Panels

This block produces the timing for a parallel RGB TFT panel: horizontal sync, vertical sync, data enable, a pixel-clock phase signal, blanked pixel data, and one-cycle start-of-frame and end-of-frame markers. Two free-running counters, one for pixels and one for lines, advance on a pixel-clock enable. Every output window is compared against these counters.

Each window is given as a 32-bit word. The upper half is the first position at which the signal is active. The lower half is the first position at which it is no longer active. A fifth word holds the line length in pixels in its upper half and the frame length in lines in its lower half. Each signal has its own polarity input: hsync, vsync, data enable, the pixel-clock phase and the data bits can be inverted independently.

In a typical setup, hsync runs from pixel 0 to the sync width and vsync from line 0 to the sync width. The active windows start after sync plus back porch and last for the visible width and height. All outputs are registered, so every output reflects the counter values shown on `hcnt_o` and `vcnt_o` in the same cycle.

Top module: `panel_timing_gen`

## Requirements
- R1: While `run_i` is low, and after reset, the following hold one clock edge after `run_i` is sampled low. `hcnt_o` and `vcnt_o` are 0. `pix_data_o` is 0. `sof_o` and `eof_o` are 0. `hsync_o`, `vsync_o`, `de_o` and `pclk_o` each sit at their inactive level, which equals that signal's inversion input.
- R2: The pixel counter counts from 0 up to the line total minus 1 and then wraps to 0. On each wrap the line counter advances. The line counter wraps to 0 after the frame total minus 1.
- R3: The counters advance only at clock edges where `pix_ce_i` is high. At other edges they hold their values.
- R4: `hsync_o` is active while `hcnt_o` is greater than or equal to window bits 31:16 and less than window bits 15:0. The active level is 1, or 0 when `hs_inv_i` is 1.
- R5: `vsync_o` follows the same rule, applied to `vcnt_o` and its own window, with `vs_inv_i` selecting the polarity.
- R6: `de_o` is active only when `hcnt_o` lies in the horizontal active window and `vcnt_o` lies in the vertical active window. `de_inv_i` inverts it.
- R7: `pix_data_o` is the value of `pix_data_i` sampled at the same edge, XORed with all ones when `dat_inv_i` is 1, but only while data enable is active. Outside that window it is 0.
- R8: `sof_o` is high for exactly the one cycle in which pixel 0 of line 0 is shown and was consumed by a pixel-clock enable.
- R9: `eof_o` is high for the one cycle in which the last pixel of the last active line is shown with a pixel-clock enable. The last pixel is at horizontal active end minus 1; the last active line is at vertical active end minus 1.
- R10: `pclk_o` is 1 in a cycle whose pixel was consumed by an enable, and 0 otherwise. `pclk_fall_i` inverts it.
- R11: A window whose start is greater than or equal to its end is never active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Timing enable; low holds the counters at zero |
| pix_ce_i | input | 1 | Pixel-clock enable, advances the counters |
| hsync_win_i | input | 32 | Hsync window, start in 31:16 and end in 15:0 |
| vsync_win_i | input | 32 | Vsync window, as lines |
| hact_win_i | input | 32 | Horizontal visible window |
| vact_win_i | input | 32 | Vertical visible window |
| total_i | input | 32 | Line total in 31:16, frame total in 15:0 |
| hs_inv_i | input | 1 | Hsync active low |
| vs_inv_i | input | 1 | Vsync active low |
| de_inv_i | input | 1 | Data enable active low |
| pclk_fall_i | input | 1 | Pixel-clock phase inverted (falling-edge sampling) |
| dat_inv_i | input | 1 | Invert visible data bits |
| pix_data_i | input | 24 | Pixel word to display |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_o | output | 1 | Pixel-clock phase |
| pix_data_o | output | 24 | Blanked, optionally inverted pixel data |
| hcnt_o | output | 16 | Pixel position of the current output cycle |
| vcnt_o | output | 16 | Line position of the current output cycle |
| sof_o | output | 1 | Start-of-frame pulse |
| eof_o | output | 1 | End-of-frame pulse |

## Verification
The hardest conditions to reach are the frame-level events: the line counter wrapping and the single start and end-of-frame pulses. On a real panel geometry these occur only once in about a hundred thousand pixels. The bench therefore runs one complete 320 x 240 frame, with 408 pixels per line and 262 lines, plus a short tail. It checks every cycle against window arithmetic computed from the reported counters and counts the frame pulses. A miniature geometry then exercises inversions, sparse enables, empty windows and mid-frame disable in a few hundred cycles.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
   localparam int FLD_W = 16;
   localparam int REG_W = 2 * FLD_W;
   localparam int N_WIN = 4;

   typedef enum logic [1:0] {
      WIN_HSYNC = 2'd0,
      WIN_VSYNC = 2'd1,
      WIN_HACT  = 2'd2,
      WIN_VACT  = 2'd3
   } win_idx_e;

   typedef struct packed {
      logic hs;
      logic vs;
      logic de;
      logic pclk;
      logic dat;
   } pol_t;
endpackage

// File: rtl/lcdtg_counter.sv
module lcdtg_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          ce_i,
   input  logic [CW-1:0] htot_i,
   input  logic [CW-1:0] vtot_i,
   output logic [CW-1:0] h_o,
   output logic [CW-1:0] v_o
);
   localparam int XW = CW + 1;

   logic [CW-1:0] h_q, v_q;
   logic          h_last, v_last;

   always_comb begin
      h_last = ({1'b0, h_q} + XW'(1)) >= {1'b0, htot_i};
      v_last = ({1'b0, v_q} + XW'(1)) >= {1'b0, vtot_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q <= '0;
         v_q <= '0;
      end else if (!run_i) begin
         h_q <= '0;
         v_q <= '0;
      end else if (ce_i) begin
         if (h_last) begin
            h_q <= '0;
            v_q <= v_last ? '0 : v_q + CW'(1);
         end else begin
            h_q <= h_q + CW'(1);
         end
      end
   end

   assign h_o = h_q;
   assign v_o = v_q;

   a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (h_q == '0 && v_q == '0));
   a_r3_hold_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !ce_i) |=> ($stable(h_q) && $stable(v_q)));
   a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && ce_i && h_last) |=> (h_q == '0));
endmodule

// File: rtl/lcdtg_window.sv
module lcdtg_window #(
   parameter int CW = 16
) (
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] start_i,
   input  logic [CW-1:0] stop_i,
   output logic          hit_o
);
   always_comb hit_o = (cnt_i >= start_i) && (cnt_i < stop_i);
endmodule

// File: rtl/lcdtg_outstage.sv
module lcdtg_outstage
   import lcdtg_pkg::*;
#(
   parameter int CW        = 16,
   parameter int DW        = 24,
   parameter bit DAT_INV_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          ce_i,
   input  logic [CW-1:0] h_i,
   input  logic [CW-1:0] v_i,
   input  logic [N_WIN-1:0] hit_i,
   input  logic [CW-1:0] hact_end_i,
   input  logic [CW-1:0] vact_end_i,
   input  logic [CW-1:0] htot_i,
   input  pol_t          pol_i,
   input  logic [DW-1:0] pix_i,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          de_o,
   output logic          pclk_o,
   output logic [DW-1:0] pix_o,
   output logic [CW-1:0] hcnt_o,
   output logic [CW-1:0] vcnt_o,
   output logic          sof_o,
   output logic          eof_o
);
   localparam int XW = CW + 1;

   logic          hs_act, vs_act, de_act, take;
   logic          sof_d, eof_d;
   logic [DW-1:0] dmask;

   generate
      if (DAT_INV_EN) begin : g_dinv
         assign dmask = {DW{pol_i.dat}};
      end else begin : g_nodinv
         assign dmask = '0;
      end
   endgenerate

   always_comb begin
      take   = run_i && ce_i;
      hs_act = run_i && hit_i[WIN_HSYNC];
      vs_act = run_i && hit_i[WIN_VSYNC];
      de_act = run_i && hit_i[WIN_HACT] && hit_i[WIN_VACT];
      sof_d  = take && (h_i == '0) && (v_i == '0);
      eof_d  = take && (({1'b0, h_i} + XW'(1)) == {1'b0, hact_end_i})
                    && (({1'b0, v_i} + XW'(1)) == {1'b0, vact_end_i});
   end

   logic          hs_q, vs_q, de_q, pclk_q, sof_q, eof_q;
   logic [DW-1:0] pix_q;
   logic [CW-1:0] hc_q, vc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q   <= 1'b0;
         vs_q   <= 1'b0;
         de_q   <= 1'b0;
         pclk_q <= 1'b0;
         sof_q  <= 1'b0;
         eof_q  <= 1'b0;
         pix_q  <= '0;
         hc_q   <= '0;
         vc_q   <= '0;
      end else begin
         hs_q   <= hs_act;
         vs_q   <= vs_act;
         de_q   <= de_act;
         pclk_q <= take;
         sof_q  <= sof_d;
         eof_q  <= eof_d;
         pix_q  <= de_act ? (pix_i ^ dmask) : '0;
         hc_q   <= run_i ? h_i : '0;
         vc_q   <= run_i ? v_i : '0;
      end
   end

   assign hsync_o = hs_q ^ pol_i.hs;
   assign vsync_o = vs_q ^ pol_i.vs;
   assign de_o    = de_q ^ pol_i.de;
   assign pclk_o  = pclk_q ^ pol_i.pclk;
   assign pix_o   = pix_q;
   assign hcnt_o  = hc_q;
   assign vcnt_o  = vc_q;
   assign sof_o   = sof_q;
   assign eof_o   = eof_q;

   a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (pix_q == '0 && !sof_q && !eof_q && !hs_q && !vs_q && !de_q));
   a_r7_blank_data: assert property (@(posedge clk) disable iff (!rst_n)
      !de_q |-> (pix_q == '0));
   a_r8_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_q && htot_i > CW'(1) && $stable(htot_i)) |=> !sof_q);
   a_r6_de_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (de_q && run_i && $stable(hact_end_i)) |-> (hc_q < hact_end_i));
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
   import lcdtg_pkg::*;
#(
   parameter int CW         = 16,
   parameter int DW         = 24,
   parameter bit DAT_INV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             pix_ce_i,
   input  logic [REG_W-1:0] hsync_win_i,
   input  logic [REG_W-1:0] vsync_win_i,
   input  logic [REG_W-1:0] hact_win_i,
   input  logic [REG_W-1:0] vact_win_i,
   input  logic [REG_W-1:0] total_i,
   input  logic             hs_inv_i,
   input  logic             vs_inv_i,
   input  logic             de_inv_i,
   input  logic             pclk_fall_i,
   input  logic             dat_inv_i,
   input  logic [DW-1:0]    pix_data_i,
   output logic             hsync_o,
   output logic             vsync_o,
   output logic             de_o,
   output logic             pclk_o,
   output logic [DW-1:0]    pix_data_o,
   output logic [CW-1:0]    hcnt_o,
   output logic [CW-1:0]    vcnt_o,
   output logic             sof_o,
   output logic             eof_o
);
   initial begin
      assert (CW >= 2 && CW <= FLD_W) else $error("CW must lie in 2..%0d", FLD_W);
      assert (DW >= 1) else $error("DW must be positive");
   end

   logic [CW-1:0] htot, vtot, h_cnt, v_cnt;
   logic [REG_W-1:0] win_reg [N_WIN];
   logic [CW-1:0] w_start [N_WIN];
   logic [CW-1:0] w_stop  [N_WIN];
   logic [CW-1:0] w_cnt   [N_WIN];
   logic [N_WIN-1:0] hits;
   pol_t pol;

   assign htot = total_i[FLD_W +: CW];
   assign vtot = total_i[0 +: CW];

   assign win_reg[WIN_HSYNC] = hsync_win_i;
   assign win_reg[WIN_VSYNC] = vsync_win_i;
   assign win_reg[WIN_HACT]  = hact_win_i;
   assign win_reg[WIN_VACT]  = vact_win_i;

   assign pol = '{hs: hs_inv_i, vs: vs_inv_i, de: de_inv_i,
                  pclk: pclk_fall_i, dat: dat_inv_i};

   lcdtg_counter #(.CW(CW)) i_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_i),
      .ce_i   (pix_ce_i),
      .htot_i (htot),
      .vtot_i (vtot),
      .h_o    (h_cnt),
      .v_o    (v_cnt)
   );

   generate
      for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
         assign w_start[gi] = win_reg[gi][FLD_W +: CW];
         assign w_stop[gi]  = win_reg[gi][0 +: CW];
         if (gi == WIN_HSYNC || gi == WIN_HACT) begin : g_h
            assign w_cnt[gi] = h_cnt;
         end else begin : g_v
            assign w_cnt[gi] = v_cnt;
         end
         lcdtg_window #(.CW(CW)) i_win (
            .cnt_i   (w_cnt[gi]),
            .start_i (w_start[gi]),
            .stop_i  (w_stop[gi]),
            .hit_o   (hits[gi])
         );
      end
   endgenerate

   lcdtg_outstage #(.CW(CW), .DW(DW), .DAT_INV_EN(DAT_INV_EN)) i_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_i),
      .ce_i       (pix_ce_i),
      .h_i        (h_cnt),
      .v_i        (v_cnt),
      .hit_i      (hits),
      .hact_end_i (w_stop[WIN_HACT]),
      .vact_end_i (w_stop[WIN_VACT]),
      .htot_i     (htot),
      .pol_i      (pol),
      .pix_i      (pix_data_i),
      .hsync_o    (hsync_o),
      .vsync_o    (vsync_o),
      .de_o       (de_o),
      .pclk_o     (pclk_o),
      .pix_o      (pix_data_o),
      .hcnt_o     (hcnt_o),
      .vcnt_o     (vcnt_o),
      .sof_o      (sof_o),
      .eof_o      (eof_o)
   );
endmodule

// File: tb/test_panel_timing_gen.sv
module test_panel_timing_gen;
   localparam int CW = 16;
   localparam int DW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run = 1'b0, ce = 1'b0;
   logic [31:0] hs_w, vs_w, ha_w, va_w, tot_w;
   logic hs_inv = 1'b0, vs_inv = 1'b0, de_inv = 1'b0, pc_inv = 1'b0, d_inv = 1'b0;
   logic [DW-1:0] pin = '0;
   logic hsync, vsync, de, pclk, sof, eof;
   logic [DW-1:0] pout;
   logic [CW-1:0] hcnt, vcnt;

   int checks = 0, errors = 0;
   int sof_n = 0, eof_n = 0, hs_act_n = 0, hmax = 0, vmax = 0;
   int cyc = 0;
   int h_prev = 0, v_prev = 0;
   bit ce_prev = 0, run_prev = 0, have_prev = 0;

   always #10 clk = ~clk;

   panel_timing_gen #(.CW(CW), .DW(DW)) i_panel_timing_gen (
      .clk(clk), .rst_n(rst_n), .run_i(run), .pix_ce_i(ce),
      .hsync_win_i(hs_w), .vsync_win_i(vs_w), .hact_win_i(ha_w),
      .vact_win_i(va_w), .total_i(tot_w),
      .hs_inv_i(hs_inv), .vs_inv_i(vs_inv), .de_inv_i(de_inv),
      .pclk_fall_i(pc_inv), .dat_inv_i(d_inv), .pix_data_i(pin),
      .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pclk_o(pclk),
      .pix_data_o(pout), .hcnt_o(hcnt), .vcnt_o(vcnt),
      .sof_o(sof), .eof_o(eof)
   );

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-cycle reference model from the requirements, using reported counters
   task automatic check_cycle();
      int h, v, htot, vtot, eh, ev;
      bit hw, vw, aw, bw, dex, sofx, eofx;
      logic [DW-1:0] px;
      h = int'(hcnt); v = int'(vcnt);
      htot = int'(tot_w[31:16]); vtot = int'(tot_w[15:0]);
      hw = run && h >= int'(hs_w[31:16]) && h < int'(hs_w[15:0]);
      vw = run && v >= int'(vs_w[31:16]) && v < int'(vs_w[15:0]);
      aw = h >= int'(ha_w[31:16]) && h < int'(ha_w[15:0]);
      bw = v >= int'(va_w[31:16]) && v < int'(va_w[15:0]);
      dex = run && aw && bw;
      sofx = run && ce && h == 0 && v == 0;
      eofx = run && ce && (h + 1 == int'(ha_w[15:0])) && (v + 1 == int'(va_w[15:0]));
      px = dex ? (pin ^ {DW{d_inv}}) : '0;
      if (!run) begin
         chk(hcnt == 0, "R1 hcnt idle", hcnt, 0);
         chk(vcnt == 0, "R1 vcnt idle", vcnt, 0);
      end
      chk(hsync === (hw ^ hs_inv), "R4 hsync", hsync, hw ^ hs_inv);
      chk(vsync === (vw ^ vs_inv), "R5 vsync", vsync, vw ^ vs_inv);
      chk(de === (dex ^ de_inv), "R6 de", de, dex ^ de_inv);
      chk(pclk === ((run && ce) ^ pc_inv), "R10 pclk", pclk, (run && ce) ^ pc_inv);
      chk(pout === px, "R7 data", pout, px);
      chk(sof === sofx, "R8 sof", sof, sofx);
      chk(eof === eofx, "R9 eof", eof, eofx);
      if (have_prev && run && run_prev) begin
         eh = h_prev; ev = v_prev;
         if (ce_prev) begin
            if (eh + 1 >= htot) begin
               eh = 0;
               ev = (ev + 1 >= vtot) ? 0 : ev + 1;
            end else eh = eh + 1;
         end
         chk(h == eh, ce_prev ? "R2 pixel step" : "R3 pixel hold", h, eh);
         chk(v == ev, ce_prev ? "R2 line step" : "R3 line hold", v, ev);
      end
      if (sof) sof_n++;
      if (eof) eof_n++;
      if (hsync !== hs_inv) hs_act_n++;
      if (h > hmax) hmax = h;
      if (v > vmax) vmax = v;
      h_prev = h; v_prev = v; ce_prev = ce; run_prev = run; have_prev = 1;
   endtask

   task automatic tick();
      @(negedge clk);
      check_cycle();
      cyc++;
      pin = DW'(cyc * 24'h0A3B5 + 24'h11);
   endtask

   task automatic small_panel();
      tot_w = {16'd12, 16'd8};
      hs_w  = {16'd0, 16'd2};
      vs_w  = {16'd0, 16'd1};
      ha_w  = {16'd3, 16'd9};
      va_w  = {16'd2, 16'd6};
   endtask

   task automatic t_r1_reset_idle();
      small_panel();
      hs_inv = 1; vs_inv = 1; de_inv = 1; pc_inv = 1; d_inv = 1;
      ce = 1;
      repeat (3) tick();
      rst_n = 1'b1;
      repeat (4) tick();
      chk(pout == 0, "R1 reset data", pout, 0);
      chk(hsync == 1 && vsync == 1 && de == 1 && pclk == 1, "R1 inactive levels",
          {hsync, vsync, de, pclk}, 4'hF);
   endtask

   task automatic t_r2_full_frame();
      hs_inv = 1; vs_inv = 1; pc_inv = 1; de_inv = 0; d_inv = 0;
      tot_w = {16'd408, 16'd262};
      hs_w  = {16'd0, 16'd30};
      vs_w  = {16'd0, 16'd3};
      ha_w  = {16'd50, 16'd370};
      va_w  = {16'd11, 16'd251};
      run = 0; ce = 1;
      repeat (2) tick();
      sof_n = 0; eof_n = 0; hmax = 0; vmax = 0;
      run = 1;
      repeat (408 * 262 + 10) tick();
      chk(sof_n == 2, "R8 sof count", sof_n, 2);
      chk(eof_n == 1, "R9 eof count", eof_n, 1);
      chk(hmax == 407, "R2 pixel max", hmax, 407);
      chk(vmax == 261, "R2 line max", vmax, 261);
   endtask

   task automatic t_r7_inverted_small();
      run = 0;
      tick();
      small_panel();
      hs_inv = 0; vs_inv = 1; de_inv = 1; pc_inv = 0; d_inv = 1;
      run = 1; ce = 1;
      sof_n = 0; eof_n = 0;
      repeat (96 * 3) tick();
      chk(sof_n == 3, "R8 sof per frame", sof_n, 3);
      chk(eof_n == 3, "R9 eof per frame", eof_n, 3);
   endtask

   task automatic t_r3_sparse_enable();
      d_inv = 0;
      for (int i = 0; i < 300; i++) begin
         ce = (i % 3 == 0);
         tick();
      end
      ce = 0;
      repeat (4) tick();
      chk(pclk == pc_inv, "R3 pclk idle without enable", pclk, pc_inv);
      ce = 1;
   endtask

   task automatic t_r11_empty_window();
      hs_w = {16'd5, 16'd5};
      hs_act_n = 0;
      repeat (200) tick();
      chk(hs_act_n == 0, "R11 empty hsync window", hs_act_n, 0);
      hs_w = {16'd7, 16'd3};
      hs_act_n = 0;
      repeat (100) tick();
      chk(hs_act_n == 0, "R11 reversed hsync window", hs_act_n, 0);
      hs_w = {16'd0, 16'd2};
   endtask

   task automatic t_r1_mid_frame_stop();
      repeat (37) tick();
      run = 0;
      tick();
      chk(hcnt == 0 && vcnt == 0, "R1 stop clears counters", {hcnt, vcnt}, 0);
      chk(pout == 0 && sof == 0 && eof == 0, "R1 stop quiets pulses", {pout, sof, eof}, 0);
      repeat (5) tick();
      run = 1;
      sof_n = 0;
      repeat (3) tick();
      chk(sof_n == 1, "R8 sof after restart", sof_n, 1);
   endtask

   initial begin
      t_r1_reset_idle();
      t_r2_full_frame();
      t_r7_inverted_small();
      t_r3_sparse_enable();
      t_r11_empty_window();
      t_r1_mid_frame_stop();
      summary();
      $finish;
   end
endmodule